// File: doc/BRIEF.md
# Dual-Port Bridge Control Register File

This block holds the 64-bit control and status registers of a service-interface host bridge. Two requesters can reach them. A configuration port addresses a register by byte address, and the register index is that address divided by eight. A memory-mapped port addresses the same bank through a window in the system address space. The window is placed by a base register that only the configuration port may program. The memory-mapped index is the byte offset inside the window divided by eight, plus ten.

Beyond plain storage, the block provides several access rules:

- Atomic AND and OR alias indices act on the fault register.
- Set and clear alias indices act on the control register.
- Some registers apply a write mask.
- One status register is read-only and follows an external status vector.
- A misaligned access, a forbidden write or a clash between the ports raises an error pulse.
- An access to an index with no register raises an unimplemented pulse. Reads of such indices return all ones.

Every read answers exactly one cycle after its request.

Top module: `hbr_ctrl_regfile`

## Requirements
- R1: During reset and after it, every register reads zero, except the window base register (index 0x0A), which holds `DEF_BASE & 0x0003FFFFFFF00000` with the enable bit (bit 0) set. All response outputs are low while reset is held.
- R2: The configuration port selects index `cfg_addr >> 3`. The memory-mapped port selects index `((mmio_addr - window base) >> 3) + 0x0A`. Any access whose address bits [2:0] are not zero changes nothing and raises that port's error pulse. A misaligned read also returns all ones.
- R3: The fault register at index 0x00 loads the write data. A write to index 0x01 stores old AND data into it. A write to index 0x02 stores old OR data into it.
- R4: The control register at index 0x0E loads the write data. A write to index 0x12 ORs the data into it. A write to index 0x13 clears each bit that is one in the data.
- R5: The window base register at index 0x0A keeps only the data bits under `0x0003FFFFFFF00001` on a configuration write. A memory-mapped write to it changes nothing and raises `mmio_err`.
- R6: The auxiliary base register at index 0x0B keeps only the data bits under `0x0003FFFF00000000`.
- R7: The status register at index 0x15 reads the value that `irq_stat_in` had at the previous clock edge. A write to it changes nothing and raises the writing port's error pulse.
- R8: An access to any other index raises the unimplemented pulse and leaves all registers unchanged. A read of such an index returns all ones. This covers reads of the write-only aliases 0x01, 0x02, 0x12 and 0x13, indices 0x03–0x05, and every index from 0x16 up.
- R9: The memory-mapped port responds only when the base enable bit is set and `mmio_addr[49:20]` equals base bits [49:20]. On a miss it produces no read response and no pulse.
- R10: `cfg_rvalid`/`mmio_rvalid` rise for exactly the cycle after a read request. The error and unimplemented pulses last one cycle and line up with that response slot. Writes produce no rvalid.
- R11: When both ports request in the same cycle and the memory-mapped request hits the window, the configuration access is served. The memory-mapped access changes nothing and raises `mmio_err`; if it was a read, it returns all ones.
- R12: The plain registers at indices 0x06, 0x07, 0x0F and 0x14 store and return all 64 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Configuration port request |
| cfg_we | input | 1 | Configuration write (1) or read (0) |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rvalid | output | 1 | Configuration read data valid |
| cfg_rdata | output | 64 | Configuration read data |
| cfg_err | output | 1 | Configuration illegal-access pulse |
| cfg_unimp | output | 1 | Configuration unimplemented-index pulse |
| mmio_req | input | 1 | Memory-mapped request |
| mmio_we | input | 1 | Memory-mapped write (1) or read (0) |
| mmio_addr | input | ADDR_W | Memory-mapped byte address |
| mmio_wdata | input | 64 | Memory-mapped write data |
| mmio_rvalid | output | 1 | Memory-mapped read data valid |
| mmio_rdata | output | 64 | Memory-mapped read data |
| mmio_err | output | 1 | Memory-mapped illegal-access pulse |
| mmio_unimp | output | 1 | Memory-mapped unimplemented-index pulse |
| irq_stat_in | input | 64 | Status vector mirrored into index 0x15 |

## Verification
The assertions rely on several properties of the inputs:

- A request is a single-cycle strobe with well-defined `we` and address.
- `rst_n` is low at the first clock edge, so the base register's reset value is visible when reset is released.
- A request is never held across a reset edge.

The stimulus drives every request for exactly one cycle, on the falling edge. It holds `irq_stat_in` constant so the read-only register has a known value. It creates port clashes only on purpose, as paired requests within a single cycle.

// File: rtl/hbr_pkg.sv
// Shared definitions for the bridge control register file: register
// indices, write masks, write-operation encoding and the per-access rule
// record. Assumes a 6-bit register index space.
package hbr_pkg;

    localparam int IDX_W     = 6;
    localparam int NUM_SLOTS = 22;

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IX_FAULT     = 6'h00;
    localparam idx_t IX_FAULT_AND = 6'h01;
    localparam idx_t IX_FAULT_OR  = 6'h02;
    localparam idx_t IX_ACT0      = 6'h06;
    localparam idx_t IX_ACT1      = 6'h07;
    localparam idx_t IX_BASE      = 6'h0A;
    localparam idx_t IX_AUX       = 6'h0B;
    localparam idx_t IX_CTL       = 6'h0E;
    localparam idx_t IX_EMASK     = 6'h0F;
    localparam idx_t IX_CTL_SET   = 6'h12;
    localparam idx_t IX_CTL_CLR   = 6'h13;
    localparam idx_t IX_DMAHI     = 6'h14;
    localparam idx_t IX_ISTAT     = 6'h15;

    localparam logic [63:0] BASE_MASK = 64'h0003_FFFF_FFF0_0000;
    localparam logic [63:0] BASE_EN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] AUX_MASK  = 64'h0003_FFFF_0000_0000;
    localparam logic [63:0] ALL_ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_AND,
        OP_OR,
        OP_CLR
    } wop_e;

    typedef struct packed {
        wop_e        op;
        idx_t        tgt;
        logic [63:0] mask;
        logic        rd_ok;
        logic        err;
        logic        unimp;
    } rule_t;

    // True for a slot index that owns a physical register.
    function automatic bit has_storage(input int i);
        return (i == int'(IX_FAULT)) || (i == int'(IX_ACT0))  ||
               (i == int'(IX_ACT1))  || (i == int'(IX_BASE))  ||
               (i == int'(IX_AUX))   || (i == int'(IX_CTL))   ||
               (i == int'(IX_EMASK)) || (i == int'(IX_DMAHI)) ||
               (i == int'(IX_ISTAT));
    endfunction

    // Combine old contents with write data under a keep mask.
    function automatic logic [63:0] apply_op(input wop_e op,
                                             input logic [63:0] cur,
                                             input logic [63:0] dat,
                                             input logic [63:0] keep);
        logic [63:0] r;
        case (op)
            OP_LOAD: r = dat;
            OP_AND:  r = cur & dat;
            OP_OR:   r = cur | dat;
            OP_CLR:  r = cur & ~dat;
            default: r = cur;
        endcase
        return r & keep;
    endfunction

endpackage

// File: rtl/hbr_win_decode.sv
// Window decoder for the memory-mapped port. Flags a hit when the window is
// enabled and the address lies in the aligned 2**WIN_SHIFT byte window at
// the base, and maps the in-window offset to a register index (offset/8 +
// 0x0A). Assumes WIN_SHIFT > IDX_W + 3 and WIN_SHIFT < 32.
module hbr_win_decode
    import hbr_pkg::*;
#(
    parameter int ADDR_W    = 50,
    parameter int WIN_SHIFT = 20
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-WIN_SHIFT-1:0] base_hi,
    input  logic                      base_en,
    output logic                      hit,
    output logic                      aligned,
    output logic                      in_range,
    output idx_t                      idx
);

    localparam int WORD_W = WIN_SHIFT - 3;

    logic [31:0] word;

    // Compare the upper address bits with the base and check enable.
    always_comb hit = base_en && (addr[ADDR_W-1:WIN_SHIFT] == base_hi);

    // Full 8-byte accesses need the three low address bits clear.
    always_comb aligned = (addr[2:0] == 3'b000);

    // Offset in words, rebased to the first register reachable here.
    always_comb begin
        word     = 32'(addr[WIN_SHIFT-1:3]) + 32'(IX_BASE);
        in_range = (word < (32'd1 << IDX_W));
        idx      = word[IDX_W-1:0];
    end

    if (WORD_W <= IDX_W) begin : g_bad_cfg
        initial $error("window too small for the index space");
    end

endmodule

// File: rtl/hbr_access_rules.sv
// Access classifier: for one decoded access gives the write operation, the
// target register, the keep mask, whether a read returns data, and the
// error/unimplemented class. Purely combinational; assumes the index is
// only meaningful when aligned and in range.
module hbr_access_rules
    import hbr_pkg::*;
(
    input  idx_t  idx,
    input  logic  aligned,
    input  logic  in_range,
    input  logic  from_mmio,
    input  logic  we,
    output rule_t rule
);

    // Classify the access by index, port and direction.
    always_comb begin
        rule       = '0;
        rule.op    = OP_NONE;
        rule.tgt   = idx;
        rule.mask  = ALL_ONES;
        if (!aligned) begin
            rule.err = 1'b1;
        end else if (!in_range) begin
            rule.unimp = 1'b1;
        end else begin
            case (idx)
                IX_FAULT, IX_ACT0, IX_ACT1, IX_CTL, IX_EMASK, IX_DMAHI: begin
                    rule.rd_ok = 1'b1;
                    if (we) rule.op = OP_LOAD;
                end
                IX_FAULT_AND: begin
                    if (we) begin
                        rule.op  = OP_AND;
                        rule.tgt = IX_FAULT;
                    end else begin
                        rule.unimp = 1'b1;
                    end
                end
                IX_FAULT_OR: begin
                    if (we) begin
                        rule.op  = OP_OR;
                        rule.tgt = IX_FAULT;
                    end else begin
                        rule.unimp = 1'b1;
                    end
                end
                IX_CTL_SET: begin
                    if (we) begin
                        rule.op  = OP_OR;
                        rule.tgt = IX_CTL;
                    end else begin
                        rule.unimp = 1'b1;
                    end
                end
                IX_CTL_CLR: begin
                    if (we) begin
                        rule.op  = OP_CLR;
                        rule.tgt = IX_CTL;
                    end else begin
                        rule.unimp = 1'b1;
                    end
                end
                IX_BASE: begin
                    rule.rd_ok = 1'b1;
                    if (we) begin
                        if (from_mmio) begin
                            rule.err = 1'b1;
                        end else begin
                            rule.op   = OP_LOAD;
                            rule.mask = BASE_MASK | BASE_EN;
                        end
                    end
                end
                IX_AUX: begin
                    rule.rd_ok = 1'b1;
                    if (we) begin
                        rule.op   = OP_LOAD;
                        rule.mask = AUX_MASK;
                    end
                end
                IX_ISTAT: begin
                    rule.rd_ok = 1'b1;
                    if (we) rule.err = 1'b1;
                end
                default: rule.unimp = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/hbr_reg_store.sv
// Sparse register storage with one write port and two read ports. Slots
// without a register read as zero and own no flops. The status slot follows
// an external vector every cycle; the base slot resets to a configured
// value. Assumes the caller issues at most one write per cycle.
module hbr_reg_store
    import hbr_pkg::*;
#(
    parameter logic [63:0] DEF_BASE = 64'h0000_0001_2340_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  wop_e        wr_op,
    input  idx_t        wr_idx,
    input  logic [63:0] wr_mask,
    input  logic [63:0] wr_data,
    input  logic [63:0] istat_in,
    input  idx_t        rd_idx_a,
    input  idx_t        rd_idx_b,
    output logic [63:0] rd_data_a,
    output logic [63:0] rd_data_b,
    output logic [63:0] base_q
);

    localparam logic [63:0] BASE_RST = (DEF_BASE & BASE_MASK) | BASE_EN;

    logic [63:0] slots [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i == int'(IX_ISTAT)) begin : g_stat
            logic [63:0] q;
            // Mirror the external status vector, cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= istat_in;
            end
            assign slots[i] = q;
        end else if (has_storage(i)) begin : g_reg
            localparam logic [63:0] RST = (i == int'(IX_BASE)) ? BASE_RST : '0;
            logic [63:0] q;
            // Hold the register and apply the selected write operation.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RST;
                else if (wr_op != OP_NONE && wr_idx == idx_t'(i))
                    q <= apply_op(wr_op, q, wr_data, wr_mask);
            end
            assign slots[i] = q;
        end else begin : g_none
            assign slots[i] = '0;
        end
    end

    // Read port A, guarded against indices past the last slot.
    always_comb begin
        rd_data_a = '0;
        for (int k = 0; k < NUM_SLOTS; k++)
            if (rd_idx_a == idx_t'(k)) rd_data_a = slots[k];
    end

    // Read port B, same decode as port A.
    always_comb begin
        rd_data_b = '0;
        for (int k = 0; k < NUM_SLOTS; k++)
            if (rd_idx_b == idx_t'(k)) rd_data_b = slots[k];
    end

    assign base_q = slots[IX_BASE];

endmodule

// File: rtl/hbr_ctrl_regfile.sv
// Top of the dual-port bridge control register file. Decodes both ports,
// classifies each access, serialises writes with the configuration port
// first, and registers read data and error/unimplemented pulses one cycle
// after the request. Assumes requests are single-cycle strobes.
module hbr_ctrl_regfile
    import hbr_pkg::*;
#(
    parameter int          ADDR_W    = 50,
    parameter int          CFG_AW    = 8,
    parameter int          WIN_SHIFT = 20,
    parameter logic [63:0] DEF_BASE  = 64'h0000_0001_2340_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [63:0]       cfg_rdata,
    output logic              cfg_err,
    output logic              cfg_unimp,
    input  logic              mmio_req,
    input  logic              mmio_we,
    input  logic [ADDR_W-1:0] mmio_addr,
    input  logic [63:0]       mmio_wdata,
    output logic              mmio_rvalid,
    output logic [63:0]       mmio_rdata,
    output logic              mmio_err,
    output logic              mmio_unimp,
    input  logic [63:0]       irq_stat_in
);

    logic [31:0] cfg_word;
    logic        cfg_aligned;
    logic        cfg_in_range;
    idx_t        cfg_idx;
    rule_t       cfg_rule;

    logic        mm_hit;
    logic        mm_aligned;
    logic        mm_in_range;
    idx_t        mm_idx;
    rule_t       mm_rule;
    logic        mm_active;
    logic        mm_clash;

    wop_e        wr_op;
    idx_t        wr_idx;
    logic [63:0] wr_mask;
    logic [63:0] wr_data;
    logic [63:0] cfg_rd;
    logic [63:0] mm_rd;
    logic [63:0] bar_q;

    // Configuration port index: byte address divided by eight.
    always_comb begin
        cfg_word     = 32'(cfg_addr >> 3);
        cfg_aligned  = (cfg_addr[2:0] == 3'b000);
        cfg_in_range = (cfg_word < (32'd1 << IDX_W));
        cfg_idx      = cfg_word[IDX_W-1:0];
    end

    hbr_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_SHIFT (WIN_SHIFT)
    ) u_win (
        .addr     (mmio_addr),
        .base_hi  (bar_q[ADDR_W-1:WIN_SHIFT]),
        .base_en  (bar_q[0]),
        .hit      (mm_hit),
        .aligned  (mm_aligned),
        .in_range (mm_in_range),
        .idx      (mm_idx)
    );

    hbr_access_rules u_cfg_rules (
        .idx       (cfg_idx),
        .aligned   (cfg_aligned),
        .in_range  (cfg_in_range),
        .from_mmio (1'b0),
        .we        (cfg_we),
        .rule      (cfg_rule)
    );

    hbr_access_rules u_mm_rules (
        .idx       (mm_idx),
        .aligned   (mm_aligned),
        .in_range  (mm_in_range),
        .from_mmio (1'b1),
        .we        (mmio_we),
        .rule      (mm_rule)
    );

    // A memory-mapped access counts only on a window hit; it loses a clash.
    always_comb begin
        mm_active = mmio_req && mm_hit;
        mm_clash  = mm_active && cfg_req;
    end

    // Pick the single write of this cycle, configuration port first.
    always_comb begin
        wr_op   = OP_NONE;
        wr_idx  = cfg_rule.tgt;
        wr_mask = cfg_rule.mask;
        wr_data = cfg_wdata;
        if (cfg_req && cfg_we) begin
            wr_op = cfg_rule.op;
        end else if (mm_active && !mm_clash && mmio_we) begin
            wr_op   = mm_rule.op;
            wr_idx  = mm_rule.tgt;
            wr_mask = mm_rule.mask;
            wr_data = mmio_wdata;
        end
    end

    hbr_reg_store #(
        .DEF_BASE (DEF_BASE)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_op     (wr_op),
        .wr_idx    (wr_idx),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data),
        .istat_in  (irq_stat_in),
        .rd_idx_a  (cfg_idx),
        .rd_idx_b  (mm_idx),
        .rd_data_a (cfg_rd),
        .rd_data_b (mm_rd),
        .base_q    (bar_q)
    );

    // Configuration port response slot, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
            cfg_err    <= 1'b0;
            cfg_unimp  <= 1'b0;
        end else begin
            cfg_rvalid <= cfg_req && !cfg_we;
            cfg_rdata  <= (cfg_rule.rd_ok && !cfg_rule.err && !cfg_rule.unimp)
                          ? cfg_rd : ALL_ONES;
            cfg_err    <= cfg_req && cfg_rule.err;
            cfg_unimp  <= cfg_req && cfg_rule.unimp;
        end
    end

    // Memory-mapped port response slot; silent on a window miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mmio_rvalid <= 1'b0;
            mmio_rdata  <= '0;
            mmio_err    <= 1'b0;
            mmio_unimp  <= 1'b0;
        end else begin
            mmio_rvalid <= mm_active && !mmio_we;
            mmio_rdata  <= (!mm_clash && mm_rule.rd_ok && !mm_rule.err &&
                            !mm_rule.unimp) ? mm_rd : ALL_ONES;
            mmio_err    <= mm_active && (mm_clash || mm_rule.err);
            mmio_unimp  <= mm_active && !mm_clash && mm_rule.unimp;
        end
    end

endmodule

// File: rtl/hbr_ctrl_regfile_chk.sv
// Property checker for the bridge control register file, bound to the top.
// Assumes requests are single-cycle strobes and reset is low at the first
// clock edge.
module hbr_ctrl_regfile_chk
    import hbr_pkg::*;
#(
    parameter logic [63:0] DEF_BASE = 64'h0000_0001_2340_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic        cfg_rvalid,
    input logic        cfg_err,
    input logic        cfg_unimp,
    input logic        mmio_req,
    input logic        mmio_we,
    input logic        mmio_rvalid,
    input logic        mmio_err,
    input logic        mmio_unimp,
    input logic        mm_hit,
    input idx_t        mm_idx,
    input logic [63:0] bar_q
);

    localparam logic [63:0] BASE_RST = (DEF_BASE & BASE_MASK) | BASE_EN;

    assert_base_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bar_q == BASE_RST));

    assert_cfg_rsp_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_req && !cfg_we));

    assert_mmio_rsp_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_rvalid |-> $past(mmio_req && !mmio_we));

    assert_flag_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_err && cfg_unimp) && !(mmio_err && mmio_unimp));

    assert_base_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_req && mmio_we && mm_hit && mm_idx == IX_BASE)
        |=> ($stable(bar_q) && mmio_err));

    assert_window_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_rvalid |-> $past(bar_q[0]));

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_req && !mm_hit) |=> (!mmio_rvalid && !mmio_err && !mmio_unimp));

    assert_clash_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && mmio_req && mm_hit) |=> mmio_err);

endmodule

bind hbr_ctrl_regfile hbr_ctrl_regfile_chk #(
    .DEF_BASE (DEF_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_rvalid  (cfg_rvalid),
    .cfg_err     (cfg_err),
    .cfg_unimp   (cfg_unimp),
    .mmio_req    (mmio_req),
    .mmio_we     (mmio_we),
    .mmio_rvalid (mmio_rvalid),
    .mmio_err    (mmio_err),
    .mmio_unimp  (mmio_unimp),
    .mm_hit      (mm_hit),
    .mm_idx      (mm_idx),
    .bar_q       (bar_q)
);

// File: tb/sim_hbr_ctrl_regfile.sv
// Bench for the bridge control register file: a vector table walked by one
// loop, then directed tests for base moves, window enable, port clashes,
// pulse width and reset.
module sim_hbr_ctrl_regfile;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 50;
    localparam int          CFG_AW     = 8;
    localparam logic [63:0] B          = 64'h0000_0001_2340_0000;
    localparam logic [63:0] NB         = 64'h0003_FFFF_FFF0_0000;
    localparam logic [63:0] ONES       = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] ISTAT_VAL  = 64'h0000_0010_0000_0000;
    localparam int          NVEC       = 32;

    typedef struct packed {
        logic [7:0]  req;
        logic        port;
        logic        we;
        logic [63:0] addr;
        logic [63:0] wd;
        logic        rv;
        logic [63:0] rd;
        logic        err;
        logic        unimp;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{8'd3, 1'b0, 1'b1, 64'h00, 64'hF0F0_0000_0000_00FF, 1'b0, 64'h0, 1'b0, 1'b0},    // R3 load
        '{8'd3, 1'b0, 1'b0, 64'h00, 64'h0, 1'b1, 64'hF0F0_0000_0000_00FF, 1'b0, 1'b0},    // R3
        '{8'd3, 1'b0, 1'b1, 64'h08, 64'hFF00_0000_0000_000F, 1'b0, 64'h0, 1'b0, 1'b0},    // R3 AND
        '{8'd3, 1'b0, 1'b0, 64'h00, 64'h0, 1'b1, 64'hF000_0000_0000_000F, 1'b0, 1'b0},    // R3
        '{8'd3, 1'b0, 1'b1, 64'h10, 64'h0000_0000_0000_0F00, 1'b0, 64'h0, 1'b0, 1'b0},    // R3 OR
        '{8'd3, 1'b0, 1'b0, 64'h00, 64'h0, 1'b1, 64'hF000_0000_0000_0F0F, 1'b0, 1'b0},    // R3
        '{8'd4, 1'b0, 1'b1, 64'h70, 64'h8000_0000_0000_0001, 1'b0, 64'h0, 1'b0, 1'b0},    // R4 load
        '{8'd4, 1'b1, 1'b1, B+64'h40, 64'h0400_0000_0000_0010, 1'b0, 64'h0, 1'b0, 1'b0},  // R4 set, R2 map
        '{8'd4, 1'b1, 1'b0, B+64'h20, 64'h0, 1'b1, 64'h8400_0000_0000_0011, 1'b0, 1'b0},  // R4
        '{8'd4, 1'b1, 1'b1, B+64'h48, 64'h8000_0000_0000_0001, 1'b0, 64'h0, 1'b0, 1'b0},  // R4 clear
        '{8'd4, 1'b0, 1'b0, 64'h70, 64'h0, 1'b1, 64'h0400_0000_0000_0010, 1'b0, 1'b0},    // R4
        '{8'd6, 1'b0, 1'b1, 64'h58, ONES, 1'b0, 64'h0, 1'b0, 1'b0},                       // R6
        '{8'd6, 1'b1, 1'b0, B+64'h08, 64'h0, 1'b1, 64'h0003_FFFF_0000_0000, 1'b0, 1'b0},  // R6
        '{8'd5, 1'b1, 1'b1, B, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0},                           // R5 refused
        '{8'd5, 1'b0, 1'b0, 64'h50, 64'h0, 1'b1, B | 64'h1, 1'b0, 1'b0},                  // R5 unchanged
        '{8'd7, 1'b0, 1'b1, 64'hA8, ONES, 1'b0, 64'h0, 1'b1, 1'b0},                       // R7 write refused
        '{8'd7, 1'b0, 1'b0, 64'hA8, 64'h0, 1'b1, ISTAT_VAL, 1'b0, 1'b0},                  // R7
        '{8'd8, 1'b0, 1'b0, 64'h18, 64'h0, 1'b1, ONES, 1'b0, 1'b1},                       // R8 idx 3
        '{8'd8, 1'b0, 1'b1, 64'h20, 64'h0, 1'b0, 64'h0, 1'b0, 1'b1},                      // R8 idx 4 write
        '{8'd8, 1'b0, 1'b0, 64'h00, 64'h0, 1'b1, 64'hF000_0000_0000_0F0F, 1'b0, 1'b0},    // R8 no effect
        '{8'd8, 1'b1, 1'b0, B+64'h100, 64'h0, 1'b1, ONES, 1'b0, 1'b1},                    // R8 idx 0x2A
        '{8'd8, 1'b0, 1'b0, 64'h08, 64'h0, 1'b1, ONES, 1'b0, 1'b1},                       // R8 alias read
        '{8'd2, 1'b0, 1'b0, 64'h04, 64'h0, 1'b1, ONES, 1'b1, 1'b0},                       // R2 misaligned
        '{8'd2, 1'b1, 1'b0, B+64'h3, 64'h0, 1'b1, ONES, 1'b1, 1'b0},                      // R2 misaligned
        '{8'd9, 1'b1, 1'b0, B+64'h10_0000, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0},               // R9 miss
        '{8'd12, 1'b0, 1'b1, 64'h78, 64'h0000_0000_0000_1234, 1'b0, 64'h0, 1'b0, 1'b0},   // R12
        '{8'd12, 1'b1, 1'b0, B+64'h28, 64'h0, 1'b1, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R12
        '{8'd12, 1'b0, 1'b1, 64'hA0, 64'hABCD_0000_0000_ABCD, 1'b0, 64'h0, 1'b0, 1'b0},   // R12
        '{8'd12, 1'b0, 1'b0, 64'hA0, 64'h0, 1'b1, 64'hABCD_0000_0000_ABCD, 1'b0, 1'b0},   // R12
        '{8'd12, 1'b0, 1'b1, 64'h38, 64'h5555_AAAA_5555_AAAA, 1'b0, 64'h0, 1'b0, 1'b0},   // R12
        '{8'd12, 1'b0, 1'b0, 64'h38, 64'h0, 1'b1, 64'h5555_AAAA_5555_AAAA, 1'b0, 1'b0},   // R12
        '{8'd7, 1'b1, 1'b0, B+64'h58, 64'h0, 1'b1, ISTAT_VAL, 1'b0, 1'b0}                 // R7 via window
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_req = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [63:0]       cfg_wdata = '0;
    logic              cfg_rvalid;
    logic [63:0]       cfg_rdata;
    logic              cfg_err;
    logic              cfg_unimp;
    logic              mmio_req = 1'b0;
    logic              mmio_we = 1'b0;
    logic [ADDR_W-1:0] mmio_addr = '0;
    logic [63:0]       mmio_wdata = '0;
    logic              mmio_rvalid;
    logic [63:0]       mmio_rdata;
    logic              mmio_err;
    logic              mmio_unimp;
    logic [63:0]       irq_stat_in = ISTAT_VAL;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbr_ctrl_regfile #(
        .ADDR_W   (ADDR_W),
        .CFG_AW   (CFG_AW),
        .DEF_BASE (B)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_req     (cfg_req),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rvalid  (cfg_rvalid),
        .cfg_rdata   (cfg_rdata),
        .cfg_err     (cfg_err),
        .cfg_unimp   (cfg_unimp),
        .mmio_req    (mmio_req),
        .mmio_we     (mmio_we),
        .mmio_addr   (mmio_addr),
        .mmio_wdata  (mmio_wdata),
        .mmio_rvalid (mmio_rvalid),
        .mmio_rdata  (mmio_rdata),
        .mmio_err    (mmio_err),
        .mmio_unimp  (mmio_unimp),
        .irq_stat_in (irq_stat_in)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle on either or both ports; outputs valid on return.
    task automatic step(input logic c_req, input logic c_we,
                        input logic [63:0] c_a, input logic [63:0] c_d,
                        input logic m_req, input logic m_we,
                        input logic [63:0] m_a, input logic [63:0] m_d);
        cfg_req    = c_req;
        cfg_we     = c_we;
        cfg_addr   = c_a[CFG_AW-1:0];
        cfg_wdata  = c_d;
        mmio_req   = m_req;
        mmio_we    = m_we;
        mmio_addr  = m_a[ADDR_W-1:0];
        mmio_wdata = m_d;
        @(negedge clk);
        cfg_req  = 1'b0;
        mmio_req = 1'b0;
    endtask

    task automatic cfg_rd_chk(input logic [63:0] a, input logic [63:0] exp,
                              input string tag);
        step(1'b1, 1'b0, a, 64'h0, 1'b0, 1'b0, 64'h0, 64'h0);
        chk(cfg_rvalid === 1'b1, {tag, " cfg rvalid"}, 64'(cfg_rvalid), 64'h1);
        chk(cfg_rdata === exp, {tag, " cfg rdata"}, cfg_rdata, exp);
    endtask

    task automatic cfg_wr(input logic [63:0] a, input logic [63:0] d);
        step(1'b1, 1'b1, a, d, 1'b0, 1'b0, 64'h0, 64'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: outputs quiet while reset is held
        chk({cfg_rvalid, cfg_err, cfg_unimp, mmio_rvalid, mmio_err, mmio_unimp} === 6'b0,
            "R1 outputs in reset", 64'({cfg_rvalid, cfg_err, cfg_unimp,
            mmio_rvalid, mmio_err, mmio_unimp}), 64'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset values
        cfg_rd_chk(64'h50, B | 64'h1, "R1 base reset");
        cfg_rd_chk(64'h00, 64'h0, "R1 fault reset");
        cfg_rd_chk(64'h70, 64'h0, "R1 control reset");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d vec %0d", v.req, i);
            if (v.port == 1'b0) begin
                step(1'b1, v.we, v.addr, v.wd, 1'b0, 1'b0, 64'h0, 64'h0);
                chk(cfg_rvalid === v.rv, {tag, " rvalid"}, 64'(cfg_rvalid), 64'(v.rv));
                chk(cfg_err === v.err, {tag, " err"}, 64'(cfg_err), 64'(v.err));
                chk(cfg_unimp === v.unimp, {tag, " unimp"}, 64'(cfg_unimp), 64'(v.unimp));
                if (v.rv) chk(cfg_rdata === v.rd, {tag, " rdata"}, cfg_rdata, v.rd);
            end else begin
                step(1'b0, 1'b0, 64'h0, 64'h0, 1'b1, v.we, v.addr, v.wd);
                chk(mmio_rvalid === v.rv, {tag, " rvalid"}, 64'(mmio_rvalid), 64'(v.rv));
                chk(mmio_err === v.err, {tag, " err"}, 64'(mmio_err), 64'(v.err));
                chk(mmio_unimp === v.unimp, {tag, " unimp"}, 64'(mmio_unimp), 64'(v.unimp));
                if (v.rv) chk(mmio_rdata === v.rd, {tag, " rdata"}, mmio_rdata, v.rd);
            end
        end

        // R5/R9: move the window to the top of the masked range
        cfg_wr(64'h50, ONES);
        cfg_rd_chk(64'h50, NB | 64'h1, "R5 base mask");
        step(1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, NB + 64'h20, 64'h0);
        chk(mmio_rvalid === 1'b1 && mmio_rdata === 64'h0400_0000_0000_0010,
            "R9 new window read", mmio_rdata, 64'h0400_0000_0000_0010);
        step(1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, B + 64'h20, 64'h0);
        chk(mmio_rvalid === 1'b0, "R9 old window miss", 64'(mmio_rvalid), 64'h0);

        // R9: window disabled when the enable bit is clear
        cfg_wr(64'h50, B);
        step(1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 1'b0, B + 64'h20, 64'h0);
        chk(mmio_rvalid === 1'b0 && mmio_err === 1'b0, "R9 disabled window",
            64'(mmio_rvalid), 64'h0);

        // R11: clash, memory-mapped write refused
        cfg_wr(64'h50, B | 64'h1);
        step(1'b1, 1'b0, 64'h70, 64'h0, 1'b1, 1'b1, B + 64'h20, 64'hFFFF);
        chk(cfg_rvalid === 1'b1 && cfg_rdata === 64'h0400_0000_0000_0010,
            "R11 cfg served in clash", cfg_rdata, 64'h0400_0000_0000_0010);
        chk(mmio_err === 1'b1, "R11 mmio err in clash", 64'(mmio_err), 64'h1);
        // R10: pulse is one cycle wide
        @(negedge clk);
        chk(mmio_err === 1'b0 && cfg_rvalid === 1'b0, "R10 pulse width",
            64'({mmio_err, cfg_rvalid}), 64'h0);
        cfg_rd_chk(64'h70, 64'h0400_0000_0000_0010, "R11 control unchanged");

        // R11: clash, memory-mapped read gets all ones with error
        step(1'b1, 1'b1, 64'h78, 64'h77, 1'b1, 1'b0, B + 64'h28, 64'h0);
        chk(mmio_rvalid === 1'b1 && mmio_rdata === ONES && mmio_err === 1'b1,
            "R11 mmio read refused", mmio_rdata, ONES);
        chk(cfg_rvalid === 1'b0 && cfg_err === 1'b0, "R10 write has no rvalid",
            64'({cfg_rvalid, cfg_err}), 64'h0);
        cfg_rd_chk(64'h78, 64'h77, "R11 cfg write applied");

        // R1: reset mid-run restores defaults
        do_reset();
        cfg_rd_chk(64'h00, 64'h0, "R1 fault after reset");
        cfg_rd_chk(64'h70, 64'h0, "R1 control after reset");
        cfg_rd_chk(64'h58, 64'h0, "R1 aux after reset");
        cfg_rd_chk(64'h50, B | 64'h1, "R1 base after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule